// File: doc/BRIEF.md
# Bit-Oriented Frame Transmitter with Flag/Abort Idle

This block turns host characters into a bit-oriented serial stream. Characters go first into a one-deep holding register and then into a shift register. Each character carries two markers. A start marker opens a frame with a flag, and an end marker closes the frame with a flag once that character has been sent. Inside a frame, a zero is inserted after any run of five ones, so the payload can never look like a flag or an abort.

When no frame is in progress, the line carries one of two idle patterns: back-to-back flags, or a steady run of ones that reads as a continuous abort. The host can also cut a frame short with an abort request. If the shifter finishes a character that is not the last of its frame and no next character is waiting, the block reports data late and aborts the frame. The serial rate is set by a one-cycle bit strobe, so the block runs on the system clock at any line speed.

Top module: `bitFrameTx`

## Requirements
- R1: After reset, txBit is 1, bufEmpty is 1, txActive is 0 and dataLate is 0.
- R2: While idle, with idleAbort = 0 the line repeats the flag 01111110 with a period of 8 bit times. With idleAbort = 1 the line is a continuous 1.
- R3: A character written with wrSom starts a frame: an opening flag, then the characters, then a closing flag right after the character written with wrEom. txActive is 1 while the frame is sent.
- R4: charLen holds the character length minus one (3'd0 means 1 bit, 3'd7 means 8 bits). Only that many low-order bits of each character are sent, least significant bit first. The upper bits have no effect.
- R5: Inside a frame, a 0 is inserted after every five consecutive 1 data bits. This holds across character boundaries and just before the closing flag, so a frame never carries more than six consecutive ones.
- R6: A write is accepted only when bufEmpty is 1, and bufEmpty then falls. A write while bufEmpty is 0 is ignored. bufEmpty rises when the held character moves into the shifter.
- R7: A character written without wrSom while no frame is in progress is discarded: no frame starts, and bufEmpty returns to 1.
- R8: If the shifter finishes a character written without wrEom and no character is held, dataLate goes to 1 and the line sends at least seven ones (eight are sent), then idles. dataLate stays at 1 until a write with wrSom.
- R9: A pulse on abortReq during a frame makes the next bit time start an abort of at least seven ones. The held character is discarded, and the block then returns to idle.
- R10: txIrq is 1 exactly when intEnable is 1 and bufEmpty is 1.
- R11: While txEnable is 0, the block is held idle, txBit is 1, txActive is 0 and the holding register is cleared.
- R12: One line bit is produced per cycle with bitTick = 1. txBit does not change in a cycle without bitTick while txEnable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One-cycle strobe per line bit time |
| txEnable | input | 1 | Transmitter enable |
| idleAbort | input | 1 | Idle pattern: 0 flags, 1 continuous ones |
| charLen | input | 3 | Character length minus one |
| intEnable | input | 1 | Transmit interrupt enable |
| wrStrobe | input | 1 | Host write of a character |
| wrData | input | 8 | Character to send |
| wrSom | input | 1 | Character starts a frame |
| wrEom | input | 1 | Character ends a frame |
| abortReq | input | 1 | Request to abort the current frame |
| txBit | output | 1 | Serial line output |
| bufEmpty | output | 1 | Holding register can take a character |
| txActive | output | 1 | A frame or abort is being sent |
| dataLate | output | 1 | A frame was aborted for lack of data |
| txIrq | output | 1 | Transmit interrupt request |

## Verification
The properties assume that bitTick is a single-cycle strobe. They also assume that wrStrobe and abortReq are only ever one cycle long, so a held character leaves the holding register only on a bit time or through a flush. The stimulus drives every input on the falling edge. It raises wrStrobe and abortReq for exactly one cycle, and it changes bitTick only between whole cycles. Every host write in the frame scenarios waits for bufEmpty, except the writes that are deliberately sent into a full buffer. With eight-bit characters this keeps the holding register filled ahead of the shifter, so the only data-late events are the intended ones.

// File: rtl/bitTxPkg.sv
package bitTxPkg;

  localparam int PAT_LEN = 8;
  localparam int IDX_W = $clog2(PAT_LEN);
  localparam logic [PAT_LEN-1:0] FLAG_PAT = 8'b0111_1110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_CLOSE,
    ST_ABORT
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadShift;
    logic shiftOut;
    logic clrOnes;
    logic consumeHold;
    logic flushHold;
    logic bitLoad;
    logic useData;
    logic patBit;
  } dpCtrl_t;

  // state reported by datapath to control
  typedef struct packed {
    logic holdValid;
    logic holdSom;
    logic curEom;
    logic lastBit;
    logic charDone;
    logic stuffNow;
    logic nextOnesHit;
  } dpStat_t;

endpackage

// File: rtl/bitTxDatapath.sv
module bitTxDatapath
  import bitTxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STUFF_RUN = 5,
  parameter bit LSB_FIRST = 1'b1,
  localparam int LEN_W = $clog2(DATA_W),
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int ONES_W = $clog2(STUFF_RUN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrSom,
  input  logic              wrEom,
  input  logic [LEN_W-1:0]  charLen,
  output dpStat_t           status,
  output logic              txBit
);

  logic [DATA_W-1:0] holdData;
  logic              holdSom;
  logic              holdEom;
  logic              holdValid;

  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] shNext;
  logic [DATA_W-1:0] loadVal;
  logic              headBit;
  logic [CNT_W-1:0]  bitsLeft;
  logic              curEom;
  logic [ONES_W-1:0] onesCnt;

  // bit order selection
  generate
    if (LSB_FIRST) begin : gLsb
      assign headBit = shReg[0];
      assign shNext  = shReg >> 1;
      assign loadVal = holdData;
    end else begin : gMsb
      assign headBit = shReg[DATA_W-1];
      assign shNext  = shReg << 1;
      assign loadVal = holdData << (DATA_W - 1 - int'(charLen));
    end
  endgenerate

  // holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdData  <= '0;
      holdSom   <= 1'b0;
      holdEom   <= 1'b0;
    end else if (ctrl.flushHold || ctrl.consumeHold) begin
      holdValid <= 1'b0;
    end else if (wrStrobe && !holdValid) begin
      holdValid <= 1'b1;
      holdData  <= wrData;
      holdSom   <= wrSom;
      holdEom   <= wrEom;
    end
  end

  // shifter and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      bitsLeft <= '0;
      curEom   <= 1'b0;
    end else if (ctrl.loadShift) begin
      shReg    <= loadVal;
      bitsLeft <= CNT_W'(charLen) + CNT_W'(1);
      curEom   <= holdEom;
    end else if (ctrl.shiftOut) begin
      shReg    <= shNext;
      bitsLeft <= bitsLeft - CNT_W'(1);
    end
  end

  // run of ones for zero insertion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesCnt <= '0;
    end else if (ctrl.clrOnes) begin
      onesCnt <= '0;
    end else if (ctrl.shiftOut) begin
      onesCnt <= headBit ? onesCnt + ONES_W'(1) : '0;
    end
  end

  // line output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBit <= 1'b1;
    end else if (ctrl.bitLoad) begin
      txBit <= ctrl.useData ? headBit : ctrl.patBit;
    end
  end

  assign status.holdValid   = holdValid;
  assign status.holdSom     = holdSom;
  assign status.curEom      = curEom;
  assign status.lastBit     = (bitsLeft == CNT_W'(1));
  assign status.charDone    = (bitsLeft == '0);
  assign status.stuffNow    = (onesCnt == ONES_W'(STUFF_RUN));
  assign status.nextOnesHit = (onesCnt == ONES_W'(STUFF_RUN - 1)) && headBit;

endmodule

// File: rtl/bitTxCtrl.sv
module bitTxCtrl
  import bitTxPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitTick,
  input  logic    txEnable,
  input  logic    idleAbort,
  input  logic    abortReq,
  input  logic    wrStrobe,
  input  logic    wrSom,
  input  dpStat_t status,
  output dpCtrl_t ctrl,
  output logic    txActive,
  output logic    dataLate
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAT_LEN - 1);

  txState_e         state, nextState;
  logic [IDX_W-1:0] patIdx, nextIdx;
  logic             abortPend;
  logic             takeAbort;
  logic             setLate;
  logic             charEnd;
  logic             inFrame;

  assign inFrame = (state == ST_OPEN) || (state == ST_DATA) || (state == ST_CLOSE);

  always_comb begin
    ctrl      = '0;
    nextState = state;
    nextIdx   = patIdx;
    takeAbort = 1'b0;
    setLate   = 1'b0;
    charEnd   = 1'b0;
    if (!txEnable) begin
      ctrl.flushHold = 1'b1;
      ctrl.bitLoad   = 1'b1;
      ctrl.patBit    = 1'b1;
      nextState      = ST_IDLE;
      nextIdx        = '0;
    end else if (bitTick) begin
      ctrl.bitLoad = 1'b1;
      nextIdx      = patIdx + IDX_W'(1);
      if (abortPend && inFrame) begin
        ctrl.patBit    = 1'b1;
        ctrl.flushHold = 1'b1;
        nextState      = ST_ABORT;
        nextIdx        = '0;
        takeAbort      = 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: begin
            ctrl.patBit = idleAbort ? 1'b1 : FLAG_PAT[patIdx];
            if (status.holdValid) begin
              if (!status.holdSom) begin
                ctrl.consumeHold = 1'b1;
              end else if (idleAbort || patIdx == LAST_IDX) begin
                ctrl.loadShift   = 1'b1;
                ctrl.consumeHold = 1'b1;
                nextState        = ST_OPEN;
                nextIdx          = '0;
              end
            end
          end
          ST_OPEN: begin
            ctrl.patBit = FLAG_PAT[patIdx];
            if (patIdx == LAST_IDX) begin
              ctrl.clrOnes = 1'b1;
              nextState    = ST_DATA;
              nextIdx      = '0;
            end
          end
          ST_DATA: begin
            if (status.stuffNow) begin
              ctrl.patBit  = 1'b0;
              ctrl.clrOnes = 1'b1;
              charEnd      = status.charDone;
            end else begin
              ctrl.useData  = 1'b1;
              ctrl.shiftOut = 1'b1;
              charEnd       = status.lastBit && !status.nextOnesHit;
            end
          end
          ST_CLOSE: begin
            ctrl.patBit = FLAG_PAT[patIdx];
            if (patIdx == LAST_IDX) begin
              nextState = ST_IDLE;
              nextIdx   = '0;
            end
          end
          ST_ABORT: begin
            ctrl.patBit = 1'b1;
            if (patIdx == LAST_IDX) begin
              nextState = ST_IDLE;
              nextIdx   = '0;
            end
          end
          default: begin
            ctrl.patBit = 1'b1;
            nextState   = ST_IDLE;
            nextIdx     = '0;
          end
        endcase
        if (charEnd) begin
          nextIdx = '0;
          if (status.curEom) begin
            nextState = ST_CLOSE;
          end else if (status.holdValid) begin
            ctrl.loadShift   = 1'b1;
            ctrl.consumeHold = 1'b1;
          end else begin
            nextState = ST_ABORT;
            setLate   = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      patIdx <= '0;
    end else begin
      state  <= nextState;
      patIdx <= nextIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abortPend <= 1'b0;
    end else if (!txEnable || takeAbort || !inFrame) begin
      abortPend <= 1'b0;
    end else if (abortReq) begin
      abortPend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataLate <= 1'b0;
    end else if (setLate) begin
      dataLate <= 1'b1;
    end else if (wrStrobe && wrSom) begin
      dataLate <= 1'b0;
    end
  end

  assign txActive = (state != ST_IDLE);

endmodule

// File: rtl/bitFrameTx.sv
module bitFrameTx
  import bitTxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STUFF_RUN = 5,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              txEnable,
  input  logic              idleAbort,
  input  logic [LEN_W-1:0]  charLen,
  input  logic              intEnable,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrSom,
  input  logic              wrEom,
  input  logic              abortReq,
  output logic              txBit,
  output logic              bufEmpty,
  output logic              txActive,
  output logic              dataLate,
  output logic              txIrq
);

  dpCtrl_t ctrl;
  dpStat_t status;

  bitTxCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .txEnable  (txEnable),
    .idleAbort (idleAbort),
    .abortReq  (abortReq),
    .wrStrobe  (wrStrobe),
    .wrSom     (wrSom),
    .status    (status),
    .ctrl      (ctrl),
    .txActive  (txActive),
    .dataLate  (dataLate)
  );

  bitTxDatapath #(
    .DATA_W    (DATA_W),
    .STUFF_RUN (STUFF_RUN),
    .LSB_FIRST (1'b1)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .wrStrobe (wrStrobe),
    .wrData   (wrData),
    .wrSom    (wrSom),
    .wrEom    (wrEom),
    .charLen  (charLen),
    .status   (status),
    .txBit    (txBit)
  );

  assign bufEmpty = !status.holdValid;
  assign txIrq    = intEnable && bufEmpty;

endmodule

// File: rtl/bitFrameTxChk.sv
module bitFrameTxChk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic txEnable,
  input logic wrStrobe,
  input logic wrSom,
  input logic txBit,
  input logic bufEmpty,
  input logic txActive,
  input logic dataLate
);

  // R11: disabled transmitter marks the line and drops everything
  p_mark_when_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (txBit && !txActive && bufEmpty));

  // R12: line output only moves on a bit time
  p_hold_between_ticks_r12: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && !bitTick) |=> $stable(txBit));

  // R8: late flag is sticky until a start-of-message write
  p_late_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dataLate && !(wrStrobe && wrSom)) |=> dataLate);

  // R8: a late event leaves the block busy sending ones
  p_late_aborts_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dataLate) && txEnable && bitTick) |-> (txActive ##1 txBit));

  // R6: a held character only leaves on a bit time
  p_hold_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!bufEmpty && !bitTick && txEnable) |=> !bufEmpty);

endmodule

bind bitFrameTx bitFrameTxChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .bitTick  (bitTick),
  .txEnable (txEnable),
  .wrStrobe (wrStrobe),
  .wrSom    (wrSom),
  .txBit    (txBit),
  .bufEmpty (bufEmpty),
  .txActive (txActive),
  .dataLate (dataLate)
);

// File: tb/tb_bitFrameTx.sv
`timescale 1ns/1ps
module tb_bitFrameTx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic       txEnable = 1'b1;
  logic       idleAbort = 1'b0;
  logic [2:0] charLen = 3'd7;
  logic       intEnable = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       wrSom = 1'b0;
  logic       wrEom = 1'b0;
  logic       abortReq = 1'b0;
  logic       txBit, bufEmpty, txActive, dataLate, txIrq;

  int checks = 0;
  int fails = 0;

  logic cap [1024];
  int   capN = 0;
  logic capEn = 1'b0;
  logic actSeen = 1'b0;
  logic tkS;
  logic expB [512];
  int   expN = 0;
  logic [7:0] fb [8];

  always #4 clk = ~clk;

  bitFrameTx dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .txEnable(txEnable),
    .idleAbort(idleAbort), .charLen(charLen), .intEnable(intEnable),
    .wrStrobe(wrStrobe), .wrData(wrData), .wrSom(wrSom), .wrEom(wrEom),
    .abortReq(abortReq), .txBit(txBit), .bufEmpty(bufEmpty),
    .txActive(txActive), .dataLate(dataLate), .txIrq(txIrq)
  );

  // line recorder: one sample per bit time, after the edge settles
  always @(posedge clk) begin
    tkS = bitTick;
    #2;
    if (capEn) begin
      if (txActive) actSeen = 1'b1;
      if (tkS && capN < 1024) begin
        cap[capN] = txBit;
        capN++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrRaw(input logic [7:0] d, input logic s, input logic e);
    wrData = d; wrSom = s; wrEom = e; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0; wrSom = 1'b0; wrEom = 1'b0;
  endtask

  task automatic wrChar(input logic [7:0] d, input logic s, input logic e);
    for (int g = 0; g < 2000 && !bufEmpty; g++) @(negedge clk);
    wrRaw(d, s, e);
  endtask

  task automatic startCap();
    capN = 0; actSeen = 1'b0; capEn = 1'b1;
  endtask

  task automatic waitFrameEnd();
    bit seen = 1'b0;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (txActive) seen = 1'b1;
      else if (seen) break;
    end
    step(3);
    capEn = 1'b0;
  endtask

  task automatic pushBit(input logic b);
    expB[expN] = b;
    expN++;
  endtask

  task automatic pushFlag();
    pushBit(0);
    for (int i = 0; i < 6; i++) pushBit(1);
    pushBit(0);
  endtask

  // reference frame: flag, payload with zero insertion, flag
  task automatic buildFrame(input int n, input int len);
    int ones = 0;
    expN = 0;
    pushFlag();
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < len; i++) begin
        logic b;
        b = fb[k][i];
        pushBit(b);
        ones = b ? ones + 1 : 0;
        if (ones == 5) begin
          pushBit(0);
          ones = 0;
        end
      end
    end
    pushFlag();
  endtask

  function automatic bit found();
    for (int s = 0; s + expN <= capN; s++) begin
      bit m = 1'b1;
      for (int j = 0; j < expN; j++)
        if (cap[s+j] !== expB[j]) m = 1'b0;
      if (m) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic int maxRun();
    int r = 0;
    int best = 0;
    for (int i = 0; i < capN; i++) begin
      r = (cap[i] === 1'b1) ? r + 1 : 0;
      if (r > best) best = r;
    end
    return best;
  endfunction

  task automatic sendFrame(input string req, input int n, input int len);
    charLen = 3'(len - 1);
    step(1);
    startCap();
    for (int k = 0; k < n; k++) wrChar(fb[k], k == 0, k == n - 1);
    waitFrameEnd();
    buildFrame(n, len);
    check(found(), req, "frame bit sequence present", capN, expN);
  endtask

  task automatic tReset();
    check(txBit == 1'b1, "R1", "txBit after reset", int'(txBit), 1);
    check(bufEmpty == 1'b1, "R1", "bufEmpty after reset", int'(bufEmpty), 1);
    check(txActive == 1'b0 && dataLate == 1'b0, "R1", "active/late after reset",
          int'({txActive, dataLate}), 0);
  endtask

  task automatic tIdle();
    bit per = 1'b1;
    logic ref0;
    bit st = 1'b1;
    bitTick = 1'b1;
    idleAbort = 1'b0;
    step(4);
    startCap();
    step(40);
    capEn = 1'b0;
    for (int i = 0; i + 8 < capN; i++) if (cap[i] !== cap[i+8]) per = 1'b0;
    check(per, "R2", "flag idle period 8", int'(per), 1);
    expN = 0; pushFlag();
    check(found(), "R2", "flag idle contains flag", capN, expN);
    check(maxRun() == 6, "R2", "flag idle longest ones run", maxRun(), 6);
    // R12: no ticks, no change
    bitTick = 1'b0;
    step(1);
    ref0 = txBit;
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (txBit !== ref0) st = 1'b0;
    end
    check(st, "R12", "txBit frozen without bitTick", int'(st), 1);
    bitTick = 1'b1;
    idleAbort = 1'b1;
    step(12);
    startCap();
    step(24);
    capEn = 1'b0;
    check(maxRun() == capN && capN > 20, "R2", "abort idle all ones", maxRun(), capN);
    idleAbort = 1'b0;
    step(10);
  endtask

  task automatic tFrames();
    fb[0] = 8'hA5; fb[1] = 8'h3C; fb[2] = 8'h81;
    sendFrame("R3", 3, 8);
    check(actSeen, "R3", "txActive during frame", int'(actSeen), 1);
    check(!txActive, "R3", "txActive after frame", int'(txActive), 0);
    step(10);
    fb[0] = 8'hFD;
    sendFrame("R4", 1, 3);
    step(10);
    fb[0] = 8'hFF;
    sendFrame("R4", 1, 1);
    step(10);
    fb[0] = 8'hFF; fb[1] = 8'h1F; fb[2] = 8'hF8;
    sendFrame("R5", 3, 8);
    check(maxRun() == 6, "R5", "longest ones run with stuffing", maxRun(), 6);
    step(10);
  endtask

  task automatic tBuffer();
    bitTick = 1'b0;
    intEnable = 1'b1;
    charLen = 3'd7;
    step(2);
    check(txIrq == 1'b1, "R10", "irq with empty buffer", int'(txIrq), 1);
    wrRaw(8'h5A, 1'b1, 1'b1);
    step(1);
    check(bufEmpty == 1'b0, "R6", "bufEmpty after write", int'(bufEmpty), 0);
    check(txIrq == 1'b0, "R10", "irq with full buffer", int'(txIrq), 0);
    wrRaw(8'hFF, 1'b1, 1'b1);
    step(2);
    startCap();
    bitTick = 1'b1;
    waitFrameEnd();
    fb[0] = 8'h5A;
    buildFrame(1, 8);
    check(found(), "R6", "write into full buffer ignored", capN, expN);
    intEnable = 1'b0;
    step(2);
    check(bufEmpty == 1'b1, "R6", "bufEmpty after drain", int'(bufEmpty), 1);
    check(txIrq == 1'b0, "R10", "irq masked", int'(txIrq), 0);
    step(10);
  endtask

  task automatic tDiscard();
    startCap();
    wrRaw(8'h00, 1'b0, 1'b0);
    step(30);
    capEn = 1'b0;
    check(!actSeen, "R7", "no frame from plain write", int'(actSeen), 0);
    check(bufEmpty == 1'b1, "R7", "plain write discarded", int'(bufEmpty), 1);
  endtask

  task automatic tLate();
    startCap();
    wrChar(8'h00, 1'b1, 1'b0);
    for (int g = 0; g < 300 && !dataLate; g++) @(negedge clk);
    step(12);
    capEn = 1'b0;
    check(dataLate == 1'b1, "R8", "dataLate raised", int'(dataLate), 1);
    expN = 0;
    pushFlag();
    for (int i = 0; i < 8; i++) pushBit(0);
    for (int i = 0; i < 7; i++) pushBit(1);
    check(found(), "R8", "abort follows late char", capN, expN);
    check(txActive == 1'b0, "R8", "idle after late abort", int'(txActive), 0);
    wrRaw(8'h00, 1'b0, 1'b0);
    step(20);
    check(dataLate == 1'b1, "R8", "dataLate kept over plain write", int'(dataLate), 1);
    wrRaw(8'h00, 1'b1, 1'b1);
    step(1);
    check(dataLate == 1'b0, "R8", "dataLate cleared by start write", int'(dataLate), 0);
    startCap();
    waitFrameEnd();
    step(10);
  endtask

  task automatic tAbort();
    startCap();
    wrChar(8'h00, 1'b1, 1'b0);
    for (int g = 0; g < 300 && !txActive; g++) @(negedge clk);
    step(10);
    wrRaw(8'h00, 1'b0, 1'b0);
    abortReq = 1'b1;
    step(1);
    abortReq = 1'b0;
    step(24);
    capEn = 1'b0;
    check(maxRun() >= 7, "R9", "abort run of ones", maxRun(), 7);
    check(txActive == 1'b0, "R9", "idle after abort", int'(txActive), 0);
    check(bufEmpty == 1'b1, "R9", "held char dropped", int'(bufEmpty), 1);
    check(dataLate == 1'b0, "R9", "abort is not late", int'(dataLate), 0);
    step(10);
  endtask

  task automatic tDisable();
    wrChar(8'h00, 1'b1, 1'b0);
    for (int g = 0; g < 300 && !txActive; g++) @(negedge clk);
    step(4);
    wrRaw(8'h00, 1'b0, 1'b0);
    txEnable = 1'b0;
    step(2);
    check(txBit == 1'b1, "R11", "mark while disabled", int'(txBit), 1);
    check(txActive == 1'b0, "R11", "idle while disabled", int'(txActive), 0);
    check(bufEmpty == 1'b1, "R11", "buffer cleared while disabled", int'(bufEmpty), 1);
    txEnable = 1'b1;
    step(20);
  endtask

  task automatic runAll();
    step(3);
    rstN = 1'b1;
    step(2);
    tReset();
    tIdle();
    tFrames();
    tBuffer();
    tDiscard();
    tLate();
    tAbort();
    tDisable();
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule